// File: doc/BRIEF.md
# Secure Address Firewall

This block sits in the request path between a group of bus masters and a group of slaves. It judges every request as it arrives and either passes it on to the slave side unchanged or refuses it. The decision uses four inputs: the master number, the direction of the access, the target slave, and whether the address falls inside a programmable protected window. Refused requests never reach a slave. The firewall accepts them itself and answers them with an error response that carries no data.

A second gate guards the slaves that hold cryptographic material. Until the key-loading master raises its ready line, only that master may reach them. CPU masters are also kept away from key storage and key control for good, whatever state the system is in. A sticky violation record keeps the first refused access for inspection. The protected window is set through a small configuration port that a lock bit closes.

Top module: `sec_addr_firewall`

## Requirements
- R1: The slave index is address bits [15:14]. A read by master m to slave s is refused when bit m*4+s of the read-deny table is 1, and a write when that bit of the write-deny table is 1. The defaults are: read-deny bit 10 (master 2, slave 2), write-deny bits 1 and 5 (masters 0 and 1, slave 1). For an allowed request, fwd_valid equals req_valid, req_ready equals fwd_ready, and ID, address, write flag and write data are passed through.
- R2: An address with base <= addr <= limit lies in the protected window. Only masters whose bit is set in the window-access mask (default masters 0 and 3) may reach it. All other masters are refused there.
- R3: Slave 3 is the cryptographic slave. A request to it from any master other than master 3 (the key loader) is refused unless km_ready was 1 at the previous rising clock edge.
- R4: A write from a CPU master (masters 0 and 1) to the key-storage area of the cryptographic slave is always refused, even after km_ready. The key-storage area is address bits [13:12] = 00.
- R5: A write from a CPU master to the key-control area of the cryptographic slave is always refused. The key-control area is address bits [13:12] = 01.
- R6: A refused request is never forwarded. It is accepted (req_ready high) only when no local error is pending. In the cycle after acceptance, rsp_valid and rsp_err are 1, rsp_id is the requester and rsp_rdata is all zeros. While the error is pending, req_ready stays low for refused requests.
- R7: When a slave response (sresp_valid) and a pending local error fall in the same cycle, the slave response goes out on the rsp_* ports. The local error is held and goes out in the first cycle with no slave response.
- R8: On the first refused acceptance while viol_flag is 0, the firewall sets viol_flag and captures the ID and address. Later refusals leave the record unchanged. A viol_clr pulse clears the flag, and it takes priority over a refusal accepted in the same cycle, which is then not recorded.
- R9: cfg_we loads base and limit only while the lock is clear. cfg_lock sets the lock, and the lock stays set until reset.
- R10: After reset the protected window spans the whole address space, the lock is clear, km_ready is treated as low, no local error is pending and viol_flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered by a master |
| req_ready | output | 1 | Request taken this cycle |
| req_id | input | 2 | Master number |
| req_addr | input | 16 | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| fwd_valid | output | 1 | Allowed request toward slaves |
| fwd_ready | input | 1 | Slave side takes request |
| fwd_id | output | 2 | Forwarded master number |
| fwd_addr | output | 16 | Forwarded address |
| fwd_we | output | 1 | Forwarded write flag |
| fwd_wdata | output | 32 | Forwarded write data |
| sresp_valid | input | 1 | Slave response present |
| sresp_err | input | 1 | Slave response error |
| sresp_id | input | 2 | Slave response master number |
| sresp_rdata | input | 32 | Slave read data |
| rsp_valid | output | 1 | Response to masters |
| rsp_err | output | 1 | Response error |
| rsp_id | output | 2 | Response master number |
| rsp_rdata | output | 32 | Response read data |
| km_ready | input | 1 | Key loader finished |
| cfg_we | input | 1 | Load window base and limit |
| cfg_base | input | 16 | New window base |
| cfg_limit | input | 16 | New window limit |
| cfg_lock | input | 1 | Set configuration lock |
| viol_clr | input | 1 | Clear violation record |
| viol_flag | output | 1 | A refusal has been recorded |
| viol_id | output | 2 | Master of first refusal |
| viol_addr | output | 16 | Address of first refusal |

## Verification
Two collisions are provoked on purpose. In the first, a refused request is accepted and a slave response is driven in the very next cycle and the one after it. The bench then expects the slave response on the rsp_* ports in both cycles and the zero-data error only in the third. In the second, viol_clr is pulsed in the cycle in which a new refusal is accepted, and the record is expected to end empty. The bench's behavioural model predicts the response port, req_ready and the violation record on every cycle, so a wrong priority shows up in the cycle where it happens.

// File: rtl/fw_pkg.sv
package fw_pkg;

    localparam int ID_W    = 2;
    localparam int NUM_MST = 1 << ID_W;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int SLV_W   = 2;
    localparam int NUM_SLV = 1 << SLV_W;
    localparam int OFS_W   = ADDR_W - SLV_W;
    localparam int AREA_W  = 2;
    localparam int TBL_W   = NUM_MST * NUM_SLV;

    typedef logic [ID_W-1:0]   mid_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [SLV_W-1:0]  sid_t;

    typedef enum logic [AREA_W-1:0] {
        AREA_KEY_STORE = 2'd0,
        AREA_KEY_CTRL  = 2'd1,
        AREA_OPEN_A    = 2'd2,
        AREA_OPEN_B    = 2'd3
    } area_e;

    typedef struct packed {
        mid_t  id;
        addr_t addr;
        logic  we;
    } acc_t;

    typedef struct packed {
        logic  valid;
        logic  err;
        mid_t  id;
        data_t rdata;
    } rsp_t;

    function automatic sid_t slave_of(addr_t a);
        return a[ADDR_W-1 -: SLV_W];
    endfunction

    function automatic area_e area_of(addr_t a);
        return area_e'(a[OFS_W-1 -: AREA_W]);
    endfunction

    function automatic logic in_window(addr_t a, addr_t lo, addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic is_key_area(area_e ar);
        return (ar == AREA_KEY_STORE) || (ar == AREA_KEY_CTRL);
    endfunction

endpackage

// File: rtl/fw_region_regs.sv
module fw_region_regs
    import fw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_we,
    input  addr_t cfg_base,
    input  addr_t cfg_limit,
    input  logic  cfg_lock,
    output addr_t base_q,
    output addr_t limit_q,
    output logic  lock_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            limit_q <= '1;
            lock_q  <= 1'b0;
        end else begin
            if (cfg_we && !lock_q) begin
                base_q  <= cfg_base;
                limit_q <= cfg_limit;
            end
            if (cfg_lock) begin
                lock_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fw_policy.sv
module fw_policy
    import fw_pkg::*;
#(
    parameter logic [TBL_W-1:0]   RD_DENY     = 16'h0400,
    parameter logic [TBL_W-1:0]   WR_DENY     = 16'h0022,
    parameter logic [NUM_MST-1:0] SEC_ALLOW   = 4'b1001,
    parameter logic [NUM_MST-1:0] CPU_MASK    = 4'b0011,
    parameter logic [NUM_SLV-1:0] CRYPTO_MASK = 4'b1000,
    parameter int                 KM_ID       = 3
) (
    input  acc_t  acc,
    input  addr_t base,
    input  addr_t limit,
    input  logic  chan_open,
    output logic  deny
);

    logic [NUM_SLV-1:0] rd_row [NUM_MST];
    logic [NUM_SLV-1:0] wr_row [NUM_MST];

    for (genvar m = 0; m < NUM_MST; m++) begin : g_rows
        assign rd_row[m] = RD_DENY[m*NUM_SLV +: NUM_SLV];
        assign wr_row[m] = WR_DENY[m*NUM_SLV +: NUM_SLV];
    end

    sid_t  sid;
    area_e area;
    logic  crypto_tgt;
    logic  from_km;
    logic  from_cpu;
    logic  deny_tbl;
    logic  deny_win;
    logic  deny_closed;
    logic  deny_key;

    always_comb begin
        sid        = slave_of(acc.addr);
        area       = area_of(acc.addr);
        crypto_tgt = CRYPTO_MASK[sid];
        from_km    = (acc.id == mid_t'(KM_ID));
        from_cpu   = CPU_MASK[acc.id];

        deny_tbl    = acc.we ? wr_row[acc.id][sid] : rd_row[acc.id][sid];
        deny_win    = in_window(acc.addr, base, limit) && !SEC_ALLOW[acc.id];
        deny_closed = crypto_tgt && !from_km && !chan_open;
        deny_key    = crypto_tgt && from_cpu && acc.we && is_key_area(area);

        deny = deny_tbl || deny_win || deny_closed || deny_key;
    end

endmodule

// File: rtl/fw_err_merge.sv
module fw_err_merge
    import fw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_err,
    input  mid_t  take_id,
    input  logic  sresp_valid,
    input  logic  sresp_err,
    input  mid_t  sresp_id,
    input  data_t sresp_rdata,
    output rsp_t  rsp,
    output logic  err_busy
);

    mid_t err_id_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_busy <= 1'b0;
            err_id_q <= '0;
        end else if (take_err) begin
            err_busy <= 1'b1;
            err_id_q <= take_id;
        end else if (err_busy && !sresp_valid) begin
            err_busy <= 1'b0;
        end
    end

    always_comb begin
        if (sresp_valid) begin
            rsp.valid = 1'b1;
            rsp.err   = sresp_err;
            rsp.id    = sresp_id;
            rsp.rdata = sresp_rdata;
        end else begin
            rsp.valid = err_busy;
            rsp.err   = err_busy;
            rsp.id    = err_id_q;
            rsp.rdata = '0;
        end
    end

endmodule

// File: rtl/fw_violation_log.sv
module fw_violation_log
    import fw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  hit,
    input  mid_t  hit_id,
    input  addr_t hit_addr,
    output logic  flag,
    output mid_t  rec_id,
    output addr_t rec_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag     <= 1'b0;
            rec_id   <= '0;
            rec_addr <= '0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (hit && !flag) begin
            flag     <= 1'b1;
            rec_id   <= hit_id;
            rec_addr <= hit_addr;
        end
    end

endmodule

// File: rtl/sec_addr_firewall.sv
module sec_addr_firewall
    import fw_pkg::*;
#(
    parameter logic [TBL_W-1:0]   RD_DENY     = 16'h0400,
    parameter logic [TBL_W-1:0]   WR_DENY     = 16'h0022,
    parameter logic [NUM_MST-1:0] SEC_ALLOW   = 4'b1001,
    parameter logic [NUM_MST-1:0] CPU_MASK    = 4'b0011,
    parameter logic [NUM_SLV-1:0] CRYPTO_MASK = 4'b1000,
    parameter int                 KM_ID       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [ID_W-1:0]   fwd_id,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              fwd_we,
    output logic [DATA_W-1:0] fwd_wdata,
    input  logic              sresp_valid,
    input  logic              sresp_err,
    input  logic [ID_W-1:0]   sresp_id,
    input  logic [DATA_W-1:0] sresp_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [ID_W-1:0]   rsp_id,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              km_ready,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              cfg_lock,
    input  logic              viol_clr,
    output logic              viol_flag,
    output logic [ID_W-1:0]   viol_id,
    output logic [ADDR_W-1:0] viol_addr
);

    acc_t  acc;
    addr_t base_q;
    addr_t limit_q;
    logic  lock_q;
    logic  km_open_q;
    logic  deny;
    logic  err_busy;
    logic  take_err;
    rsp_t  rsp;

    assign acc.id   = req_id;
    assign acc.addr = req_addr;
    assign acc.we   = req_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            km_open_q <= 1'b0;
        end else begin
            km_open_q <= km_ready;
        end
    end

    fw_region_regs u_region (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_base  (cfg_base),
        .cfg_limit (cfg_limit),
        .cfg_lock  (cfg_lock),
        .base_q    (base_q),
        .limit_q   (limit_q),
        .lock_q    (lock_q)
    );

    fw_policy #(
        .RD_DENY     (RD_DENY),
        .WR_DENY     (WR_DENY),
        .SEC_ALLOW   (SEC_ALLOW),
        .CPU_MASK    (CPU_MASK),
        .CRYPTO_MASK (CRYPTO_MASK),
        .KM_ID       (KM_ID)
    ) u_policy (
        .acc       (acc),
        .base      (base_q),
        .limit     (limit_q),
        .chan_open (km_open_q),
        .deny      (deny)
    );

    assign fwd_valid = req_valid && !deny;
    assign req_ready = deny ? !err_busy : fwd_ready;
    assign take_err  = req_valid && deny && !err_busy;
    assign fwd_id    = req_id;
    assign fwd_addr  = req_addr;
    assign fwd_we    = req_we;
    assign fwd_wdata = req_wdata;

    fw_err_merge u_merge (
        .clk         (clk),
        .rst         (rst),
        .take_err    (take_err),
        .take_id     (req_id),
        .sresp_valid (sresp_valid),
        .sresp_err   (sresp_err),
        .sresp_id    (sresp_id),
        .sresp_rdata (sresp_rdata),
        .rsp         (rsp),
        .err_busy    (err_busy)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_err   = rsp.err;
    assign rsp_id    = rsp.id;
    assign rsp_rdata = rsp.rdata;

    fw_violation_log u_vlog (
        .clk      (clk),
        .rst      (rst),
        .clr      (viol_clr),
        .hit      (take_err),
        .hit_id   (req_id),
        .hit_addr (req_addr),
        .flag     (viol_flag),
        .rec_id   (viol_id),
        .rec_addr (viol_addr)
    );

endmodule

// File: rtl/sec_addr_firewall_chk.sv
module sec_addr_firewall_chk
    import fw_pkg::*;
#(
    parameter logic [NUM_MST-1:0] CPU_MASK    = 4'b0011,
    parameter logic [NUM_SLV-1:0] CRYPTO_MASK = 4'b1000,
    parameter int                 KM_ID       = 3
) (
    input logic  clk,
    input logic  rst,
    input logic  req_valid,
    input logic  req_ready,
    input logic  fwd_valid,
    input logic  fwd_ready,
    input mid_t  fwd_id,
    input addr_t fwd_addr,
    input logic  fwd_we,
    input logic  sresp_valid,
    input logic  sresp_err,
    input mid_t  sresp_id,
    input logic  rsp_valid,
    input logic  rsp_err,
    input mid_t  rsp_id,
    input data_t rsp_rdata,
    input logic  km_ready,
    input logic  viol_clr,
    input logic  viol_flag,
    input mid_t  viol_id,
    input addr_t viol_addr,
    input addr_t base_q,
    input addr_t limit_q,
    input logic  lock_q
);

    p_fwd_handshake_r1: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (req_ready == fwd_ready));

    p_closed_channel_r3: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && CRYPTO_MASK[slave_of(fwd_addr)] && (fwd_id != mid_t'(KM_ID)))
        |-> $past(km_ready));

    p_no_key_store_write_r4: assert property (@(posedge clk) disable iff (rst)
        !(fwd_valid && fwd_we && CPU_MASK[fwd_id] && CRYPTO_MASK[slave_of(fwd_addr)]
          && (area_of(fwd_addr) == AREA_KEY_STORE)));

    p_no_key_ctrl_write_r5: assert property (@(posedge clk) disable iff (rst)
        !(fwd_valid && fwd_we && CPU_MASK[fwd_id] && CRYPTO_MASK[slave_of(fwd_addr)]
          && (area_of(fwd_addr) == AREA_KEY_CTRL)));

    p_refusal_answered_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !fwd_valid) |=> rsp_valid);

    p_local_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !sresp_valid) |-> (rsp_err && (rsp_rdata == '0)));

    p_slave_first_r7: assert property (@(posedge clk) disable iff (rst)
        sresp_valid |-> (rsp_valid && (rsp_err == sresp_err) && (rsp_id == sresp_id)));

    p_sticky_record_r8: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !viol_clr) |=> (viol_flag && $stable(viol_id) && $stable(viol_addr)));

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        viol_clr |=> !viol_flag);

    p_lock_holds_r9: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> (lock_q && $stable(base_q) && $stable(limit_q)));

endmodule

bind sec_addr_firewall sec_addr_firewall_chk #(
    .CPU_MASK    (CPU_MASK),
    .CRYPTO_MASK (CRYPTO_MASK),
    .KM_ID       (KM_ID)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .fwd_valid   (fwd_valid),
    .fwd_ready   (fwd_ready),
    .fwd_id      (fwd_id),
    .fwd_addr    (fwd_addr),
    .fwd_we      (fwd_we),
    .sresp_valid (sresp_valid),
    .sresp_err   (sresp_err),
    .sresp_id    (sresp_id),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_id      (rsp_id),
    .rsp_rdata   (rsp_rdata),
    .km_ready    (km_ready),
    .viol_clr    (viol_clr),
    .viol_flag   (viol_flag),
    .viol_id     (viol_id),
    .viol_addr   (viol_addr),
    .base_q      (base_q),
    .limit_q     (limit_q),
    .lock_q      (lock_q)
);

// File: tb/sec_addr_firewall_tb_top.sv
module sec_addr_firewall_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_we;
    logic [1:0]  req_id;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        fwd_valid, fwd_ready, fwd_we;
    logic [1:0]  fwd_id;
    logic [15:0] fwd_addr;
    logic [31:0] fwd_wdata;
    logic        sresp_valid, sresp_err;
    logic [1:0]  sresp_id;
    logic [31:0] sresp_rdata;
    logic        rsp_valid, rsp_err;
    logic [1:0]  rsp_id;
    logic [31:0] rsp_rdata;
    logic        km_ready, cfg_we, cfg_lock, viol_clr;
    logic [15:0] cfg_base, cfg_limit;
    logic        viol_flag;
    logic [1:0]  viol_id;
    logic [15:0] viol_addr;

    always #10 clk = ~clk;

    sec_addr_firewall dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_id(fwd_id),
        .fwd_addr(fwd_addr), .fwd_we(fwd_we), .fwd_wdata(fwd_wdata),
        .sresp_valid(sresp_valid), .sresp_err(sresp_err), .sresp_id(sresp_id),
        .sresp_rdata(sresp_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_id(rsp_id), .rsp_rdata(rsp_rdata),
        .km_ready(km_ready), .cfg_we(cfg_we), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_lock(cfg_lock),
        .viol_clr(viol_clr), .viol_flag(viol_flag), .viol_id(viol_id), .viol_addr(viol_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_kr, m_lock, m_busy, m_vf;
    int m_base, m_limit, m_eid, m_vid, m_vaddr;

    localparam bit [15:0] T_RD  = 16'h0400;
    localparam bit [15:0] T_WR  = 16'h0022;
    localparam bit [3:0]  T_SEC = 4'b1001;

    function automatic bit ref_deny(int id, int addr, bit we);
        int s    = (addr >> 14) & 3;
        int area = (addr >> 12) & 3;
        if (we ? T_WR[id*4+s] : T_RD[id*4+s]) return 1;
        if (addr >= m_base && addr <= m_limit && !T_SEC[id]) return 1;
        if (s == 3 && id != 3 && !m_kr) return 1;
        if (s == 3 && id <= 1 && we && area <= 1) return 1;
        return 0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic ref_reset();
        m_kr = 0; m_lock = 0; m_busy = 0; m_vf = 0;
        m_base = 0; m_limit = 16'hFFFF; m_eid = 0; m_vid = 0; m_vaddr = 0;
    endtask

    // one clock: compare mid-cycle, then advance the model past the edge
    task automatic cyc(string tag);
        bit den, take;
        #8;
        den = ref_deny(int'(req_id), int'(req_addr), req_we);
        chk(tag, "fwd_valid", 32'(fwd_valid), 32'(req_valid && !den));
        chk(tag, "req_ready", 32'(req_ready), 32'(den ? !m_busy : fwd_ready));
        if (fwd_valid) chk(tag, "fwd_addr", 32'(fwd_addr), 32'(req_addr));
        if (sresp_valid) begin
            chk(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
            chk(tag, "rsp_err", 32'(rsp_err), 32'(sresp_err));
            chk(tag, "rsp_id", 32'(rsp_id), 32'(sresp_id));
            chk(tag, "rsp_rdata", rsp_rdata, sresp_rdata);
        end else if (m_busy) begin
            chk(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
            chk(tag, "rsp_err", 32'(rsp_err), 32'd1);
            chk(tag, "rsp_id", 32'(rsp_id), 32'(m_eid));
            chk(tag, "rsp_rdata", rsp_rdata, 32'd0);
        end else begin
            chk(tag, "rsp_valid", 32'(rsp_valid), 32'd0);
        end
        chk(tag, "viol_flag", 32'(viol_flag), 32'(m_vf));
        if (m_vf) begin
            chk(tag, "viol_id", 32'(viol_id), 32'(m_vid));
            chk(tag, "viol_addr", 32'(viol_addr), 32'(m_vaddr));
        end
        take = req_valid && den && !m_busy;
        @(posedge clk);
        #1;
        if (viol_clr) m_vf = 0;
        else if (take && !m_vf) begin
            m_vf = 1; m_vid = int'(req_id); m_vaddr = int'(req_addr);
        end
        if (take) begin
            m_busy = 1; m_eid = int'(req_id);
        end else if (m_busy && !sresp_valid) m_busy = 0;
        if (cfg_we && !m_lock) begin
            m_base = int'(cfg_base); m_limit = int'(cfg_limit);
        end
        if (cfg_lock) m_lock = 1;
        m_kr = km_ready;
    endtask

    task automatic idle();
        req_valid = 0; cfg_we = 0; cfg_lock = 0; viol_clr = 0; sresp_valid = 0;
    endtask

    task automatic req(string tag, int id, int addr, bit we);
        req_valid = 1; req_id = 2'(id); req_addr = 16'(addr); req_we = we;
        req_wdata = 32'hC0DE_0000 + 32'(addr);
        cyc(tag);
        req_valid = 0;
        cyc(tag);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; idle(); fwd_ready = 1; km_ready = 0;
        req_id = 0; req_addr = 0; req_we = 0; req_wdata = 0;
        sresp_err = 0; sresp_id = 0; sresp_rdata = 0; cfg_base = 0; cfg_limit = 0;
        repeat (3) @(posedge clk);
        #1; rst = 0; ref_reset();

        // R10: reset state, whole space protected
        cyc("R10");
        req("R10", 2, 16'h0100, 0);
        req("R10", 0, 16'h0100, 0);

        // R8: second refusal does not overwrite the record, then clear
        req("R8", 1, 16'h0200, 0);
        viol_clr = 1; cyc("R8"); viol_clr = 0; cyc("R8");

        // R9: program window, lock, attempted reprogram ignored
        cfg_we = 1; cfg_base = 16'h2000; cfg_limit = 16'h2FFF; cyc("R9");
        cfg_we = 0; cfg_lock = 1; cyc("R9");
        cfg_lock = 0; cfg_we = 1; cfg_base = 16'h0000; cfg_limit = 16'hFFFF; cyc("R9");
        cfg_we = 0;
        // R2: window edges
        req("R2", 1, 16'h2000, 0);
        req("R2", 1, 16'h2FFF, 1);
        req("R2", 1, 16'h1FFF, 0);
        req("R2", 1, 16'h3000, 0);
        req("R2", 0, 16'h2100, 1);
        req("R9", 2, 16'h0100, 0);

        // R1: per-master tables
        req("R1", 2, 16'h8000, 0);
        req("R1", 2, 16'h8000, 1);
        req("R1", 0, 16'h4000, 1);
        req("R1", 0, 16'h4000, 0);
        req("R1", 1, 16'h4010, 1);
        fwd_ready = 0; req("R1", 0, 16'h0040, 0); fwd_ready = 1;

        // R3: crypto channel closed until ready
        req("R3", 2, 16'hF000, 0);
        req("R3", 3, 16'hC000, 1);
        km_ready = 1; cyc("R3");
        req("R3", 2, 16'hF000, 0);
        km_ready = 0; cyc("R3");
        req("R3", 2, 16'hF000, 0);
        km_ready = 1; cyc("R3");

        // R4 / R5: CPU key writes refused even when open
        req("R4", 0, 16'hC004, 1);
        req("R5", 1, 16'hD000, 1);
        req("R5", 0, 16'hD100, 1);
        req("R4", 0, 16'hC000, 0);
        req("R4", 0, 16'hE000, 1);
        req("R4", 2, 16'hC000, 1);

        // R6: refused request held while error pending
        req_valid = 1; req_id = 2; req_addr = 16'h8004; req_we = 0;
        cyc("R6"); cyc("R6"); cyc("R6");
        req_valid = 0; cyc("R6"); cyc("R6");

        // R7: slave response collides with pending local error
        req_valid = 1; req_id = 1; req_addr = 16'h4020; req_we = 1; cyc("R7");
        req_valid = 0; sresp_valid = 1; sresp_err = 0; sresp_id = 3;
        sresp_rdata = 32'h1234_5678; cyc("R7");
        sresp_id = 0; sresp_err = 1; sresp_rdata = 32'h9ABC_DEF0; cyc("R7");
        sresp_valid = 0; cyc("R7"); cyc("R7");

        // R8: clear and refusal in the same cycle
        viol_clr = 1; req_valid = 1; req_id = 2; req_addr = 16'h8008; req_we = 0;
        cyc("R8");
        viol_clr = 0; req_valid = 0; cyc("R8"); cyc("R8");
        req("R8", 1, 16'h2222, 0);
        cyc("R8");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule